// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor load/store port and a slower main memory. It holds 4 KB of recently used data as 128 sets of two 16-byte lines. Each line has a tag and a valid bit, and each set has one replacement bit. A read that finds its line returns the word in the cycle it is presented. A read that misses fetches the whole line from memory in one wide transfer. It places the line in a free way if the set has one, and otherwise in the way the replacement bit marks as older. It returns the requested word in the same cycle as the memory acknowledge.

Every processor write goes to main memory, so memory always holds the newest data. A write that finds its line also merges its enabled bytes into the cached copy in the same operation. A write that misses leaves the cache contents unchanged. The processor sees a write as complete only when memory acknowledges it. Only one memory transaction is outstanding at any time.

The processor holds a request and all of its fields steady until `cpu_ready` is high at a clock edge. It may then present the next request in the following cycle.

Top module: `wt_cache2w`

## Requirements
- R1: After reset every line is invalid. `cpu_ready` and `mem_req` are low, and the first read of any address misses.
- R2: Address fields are split as follows: tag = addr[31:11], set = addr[10:4], word = addr[3:2], byte = addr[1:0]. A refill request carries the line address with bits [3:0] equal to zero.
- R3: A read hit raises `cpu_ready` in the cycle the request is first presented. It returns the addressed word and makes no memory request.
- R4: On a read miss, `mem_req` rises in the next cycle with `mem_we` low. When `mem_ack` arrives, `cpu_ready` rises in that cycle with `mem_rline[word*32 +: 32]`, and the line is valid from then on.
- R5: Two lines with the same set index and different tags can be resident at once, and both hit.
- R6: A refill goes to an invalid way of the set first, with way 0 before way 1. Otherwise it goes to the way not most recently used. Read hits, write hits and refills all count as use.
- R7: Every write issues a memory write with the processor's full address, data and byte enables. `cpu_ready` for a write rises only in the cycle of `mem_ack`.
- R8: A write hit merges the enabled bytes into the cached line. A later read hit returns the merged word without a memory request.
- R9: A write miss does not allocate a line, so a later read of that address misses.
- R10: `mem_req` and its address and direction stay stable from assertion until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Write byte enables |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready on reads |
| cpu_ready | output | 1 | Request completes at this edge |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = word write-through, 0 = line refill |
| mem_addr | output | 32 | Word address for writes, line address for refills |
| mem_wdata | output | 32 | Write-through data |
| mem_be | output | 4 | Write-through byte enables |
| mem_rline | input | 128 | Refill line, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current transaction |

## Verification
The properties assume that the processor keeps a request and its address, data and enables unchanged from first presentation until `cpu_ready`. They also assume that memory raises `mem_ack` only while `mem_req` is high, for one cycle. The bench keeps within both rules by driving each access from one task. The task holds the fields constant through the whole transaction, and the memory responder pulses the acknowledge a fixed number of cycles after the request. It then inserts one idle cycle before the next access. Set and tag values come from a small pool, which forces conflicts, evictions and write misses within a few sets.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
   localparam int WTC_WAYS = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WTHRU = 2'd2
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
`timescale 1ns/1ps
module wtc_tag_store import wtc_pkg::*; #(
   parameter int TAG_W = 21,
   parameter int IDX_W = 7,
   localparam int SETS = 1 << IDX_W
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [IDX_W-1:0]                   rd_idx,
   output logic [WTC_WAYS-1:0][TAG_W-1:0]     rd_tag,
   output logic [WTC_WAYS-1:0]                rd_vld,
   input  logic                               wr_en,
   input  logic                               wr_way,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [TAG_W-1:0]                   wr_tag
);
   for (genvar w = 0; w < WTC_WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tags [SETS];
      logic [SETS-1:0]  vld_q;

      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == 1'(w))) tags[wr_idx] <= wr_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= '0;
         else if (wr_en && (wr_way == 1'(w))) vld_q[wr_idx] <= 1'b1;
      end

      assign rd_tag[w] = tags[rd_idx];
      assign rd_vld[w] = vld_q[rd_idx];
   end
endmodule

// File: rtl/wtc_data_store.sv
`timescale 1ns/1ps
module wtc_data_store import wtc_pkg::*; #(
   parameter int LINE_W = 128,
   parameter int IDX_W  = 7,
   localparam int SETS   = 1 << IDX_W,
   localparam int LBYTES = LINE_W / 8
)(
   input  logic                               clk,
   input  logic [IDX_W-1:0]                   rd_idx,
   output logic [WTC_WAYS-1:0][LINE_W-1:0]    rd_line,
   input  logic                               wr_en,
   input  logic                               wr_way,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [LINE_W-1:0]                  wr_data,
   input  logic [LBYTES-1:0]                  wr_mask
);
   for (genvar w = 0; w < WTC_WAYS; w++) begin : g_way
      logic [LINE_W-1:0] lines [SETS];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == 1'(w))) begin
            for (int b = 0; b < LBYTES; b++) begin
               if (wr_mask[b]) lines[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
         end
      end

      assign rd_line[w] = lines[rd_idx];
   end
endmodule

// File: rtl/wtc_hit_unit.sv
`timescale 1ns/1ps
module wtc_hit_unit import wtc_pkg::*; #(
   parameter int TAG_W = 21
)(
   input  logic [WTC_WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WTC_WAYS-1:0]            way_vld,
   input  logic [TAG_W-1:0]               req_tag,
   output logic [WTC_WAYS-1:0]            hit_vec,
   output logic                           hit,
   output logic                           hit_way
);
   for (genvar w = 0; w < WTC_WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_vld[w] && (way_tag[w] == req_tag);
   end

   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];
endmodule

// File: rtl/wtc_repl.sv
`timescale 1ns/1ps
module wtc_repl import wtc_pkg::*; #(
   parameter int IDX_W = 7,
   localparam int SETS = 1 << IDX_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    idx,
   input  logic [WTC_WAYS-1:0] set_vld,
   input  logic                touch_en,
   input  logic                touch_way,
   output logic                victim
);
   logic [SETS-1:0] older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) older_q <= '0;
      else if (touch_en) older_q[idx] <= ~touch_way;
   end

   always_comb begin
      if (!set_vld[0])      victim = 1'b0;
      else if (!set_vld[1]) victim = 1'b1;
      else                  victim = older_q[idx];
   end
endmodule

// File: rtl/wt_cache2w.sv
`timescale 1ns/1ps
module wt_cache2w import wtc_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 7,
   parameter int WSEL_W = 2,
   parameter int BSEL_W = 2,
   localparam int DATA_W = 8 << BSEL_W,
   localparam int BE_W   = DATA_W / 8,
   localparam int LINE_W = DATA_W << WSEL_W,
   localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BSEL_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [BE_W-1:0]   cpu_be,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [BE_W-1:0]   mem_be,
   input  logic [LINE_W-1:0] mem_rline,
   input  logic              mem_ack
);
   localparam int OFF_W  = WSEL_W + BSEL_W;
   localparam int WORDS  = 1 << WSEL_W;
   localparam int LBYTES = LINE_W / 8;

   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for index and offset fields");
   end
   if (WSEL_W < 1) begin : g_bad_word
      $error("a line must hold at least two words");
   end
   if (BSEL_W < 1 || BSEL_W > 3) begin : g_bad_byte
      $error("byte field must be 1 to 3 bits");
   end

   logic [TAG_W-1:0]  f_tag;
   logic [IDX_W-1:0]  f_idx;
   logic [WSEL_W-1:0] f_word;

   assign f_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign f_idx  = cpu_addr[OFF_W +: IDX_W];
   assign f_word = cpu_addr[BSEL_W +: WSEL_W];

   wtc_state_e state_q, state_d;

   logic [WTC_WAYS-1:0][TAG_W-1:0]  way_tag;
   logic [WTC_WAYS-1:0]             way_vld;
   logic [WTC_WAYS-1:0][LINE_W-1:0] way_line;
   logic [WTC_WAYS-1:0]             hit_vec;
   logic                            hit;
   logic                            hit_way;
   logic                            victim;

   logic               tag_we;
   logic               dat_we;
   logic               dat_way;
   logic [LINE_W-1:0]  dat_wdata;
   logic [LBYTES-1:0]  dat_mask;
   logic               touch_en;
   logic               touch_way;
   logic               fill_sel;
   logic [LINE_W-1:0]  sel_line;
   logic [LBYTES-1:0]  word_mask;

   wtc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (f_idx),
      .rd_tag (way_tag),
      .rd_vld (way_vld),
      .wr_en  (tag_we),
      .wr_way (victim),
      .wr_idx (f_idx),
      .wr_tag (f_tag)
   );

   wtc_data_store #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_data (
      .clk     (clk),
      .rd_idx  (f_idx),
      .rd_line (way_line),
      .wr_en   (dat_we),
      .wr_way  (dat_way),
      .wr_idx  (f_idx),
      .wr_data (dat_wdata),
      .wr_mask (dat_mask)
   );

   wtc_hit_unit #(.TAG_W(TAG_W)) u_hit (
      .way_tag (way_tag),
      .way_vld (way_vld),
      .req_tag (f_tag),
      .hit_vec (hit_vec),
      .hit     (hit),
      .hit_way (hit_way)
   );

   wtc_repl #(.IDX_W(IDX_W)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (f_idx),
      .set_vld   (way_vld),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .victim    (victim)
   );

   assign word_mask = LBYTES'(cpu_be) << (int'(f_word) * BE_W);
   assign fill_sel  = (state_q == ST_FILL);
   assign dat_wdata = fill_sel ? mem_rline : {WORDS{cpu_wdata}};
   assign sel_line  = fill_sel ? mem_rline : way_line[hit_way];
   assign cpu_rdata = sel_line[int'(f_word) * DATA_W +: DATA_W];

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      tag_we    = 1'b0;
      dat_we    = 1'b0;
      dat_way   = hit_way;
      dat_mask  = word_mask;
      touch_en  = 1'b0;
      touch_way = hit_way;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req && !cpu_we) begin
               if (hit) begin
                  cpu_ready = 1'b1;
                  touch_en  = 1'b1;
               end else begin
                  state_d = ST_FILL;
               end
            end else if (cpu_req && cpu_we) begin
               if (hit) begin
                  dat_we   = 1'b1;
                  touch_en = 1'b1;
               end
               state_d = ST_WTHRU;
            end
         end
         ST_FILL: begin
            if (mem_ack) begin
               tag_we    = 1'b1;
               dat_we    = 1'b1;
               dat_way   = victim;
               dat_mask  = '1;
               touch_en  = 1'b1;
               touch_way = victim;
               cpu_ready = 1'b1;
               state_d   = ST_IDLE;
            end
         end
         ST_WTHRU: begin
            if (mem_ack) begin
               cpu_ready = 1'b1;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WTHRU);
   assign mem_we    = (state_q == ST_WTHRU);
   assign mem_addr  = mem_we ? cpu_addr : {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_wdata = cpu_wdata;
   assign mem_be    = cpu_be;
endmodule

// File: rtl/wtc_checker.sv
`timescale 1ns/1ps
module wtc_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [BE_W-1:0]   cpu_be,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [BE_W-1:0]   mem_be,
   input logic              mem_ack,
   input logic [1:0]        hit_vec
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

   AST_FILL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> mem_addr[3:0] == 4'd0); // R2

   AST_WR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr == cpu_addr && mem_wdata == cpu_wdata && mem_be == cpu_be); // R7

   AST_WR_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && cpu_we |-> mem_ack && mem_req && mem_we); // R7

   AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req); // R3

   AST_READ_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && !cpu_we && !mem_ack |-> !mem_req); // R3

   AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |-> !cpu_ready); // R4

   AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R5
endmodule

bind wt_cache2w wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .cpu_be    (cpu_be),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_be    (mem_be),
   .mem_ack   (mem_ack),
   .hit_vec   (hit_vec)
);

// File: tb/wt_cache2w_tb.sv
`timescale 1ns/1ps
module wt_cache2w_tb;
   localparam int LAT = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]   cpu_be = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_ready;
   logic         mem_req, mem_we;
   logic [31:0]  mem_addr, mem_wdata;
   logic [3:0]   mem_be;
   logic [127:0] mem_rline = '0;
   logic         mem_ack = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   wt_cache2w u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rline(mem_rline), .mem_ack(mem_ack)
   );

   // behavioural model: memory contents and per-set recency list of resident tags
   logic [31:0] mem_aa [int unsigned];
   int unsigned mru_t [128];
   int unsigned lru_t [128];
   int          rcnt  [128];

   function automatic logic [31:0] mem_word(input int unsigned waddr);
      if (mem_aa.exists(waddr)) return mem_aa[waddr];
      return (waddr * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   function automatic bit model_hit(input int unsigned tg, input int st);
      return (rcnt[st] >= 1 && mru_t[st] == tg) || (rcnt[st] == 2 && lru_t[st] == tg);
   endfunction

   task automatic model_use(input int unsigned tg, input int st);
      if (rcnt[st] >= 1 && mru_t[st] == tg) return;
      if (rcnt[st] == 2 && lru_t[st] == tg) begin
         lru_t[st] = mru_t[st];
         mru_t[st] = tg;
         return;
      end
      if (rcnt[st] >= 1) lru_t[st] = mru_t[st];
      mru_t[st] = tg;
      if (rcnt[st] < 2) rcnt[st]++;
   endtask

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] mk(input int tg, input int st, input int wd);
      return {21'(tg), 7'(st), 2'(wd), 2'b00};
   endfunction

   task automatic idle(input string rq);
      @(negedge clk);
      cpu_req = 1'b0;
      mem_ack = 1'b0;
      #1;
      chk(cpu_ready == 1'b0, {rq, " idle ready"}, 32'(cpu_ready), 32'd0);
      chk(mem_req == 1'b0, {rq, " idle mem_req"}, 32'(mem_req), 32'd0);
   endtask

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                         input logic [3:0] be, input string rq);
      int unsigned tg;
      int st;
      int unsigned wa;
      int unsigned la;
      bit h;
      logic [31:0] exp_rd;
      logic [31:0] exp_ma;
      logic [31:0] merged;
      tg = a[31:11];
      st = int'(a[10:4]);
      wa = a[31:2];
      la = {a[31:4], 2'b00};
      h  = model_hit(tg, st);
      exp_ma = we ? a : {a[31:4], 4'd0};
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
      mem_ack = 1'b0;
      #1;
      if (!we && h) begin
         exp_rd = mem_word(wa);
         chk(cpu_ready == 1'b1, {rq, " R3 hit ready"}, 32'(cpu_ready), 32'd1);
         chk(cpu_rdata == exp_rd, {rq, " R3 hit data"}, cpu_rdata, exp_rd);
         chk(mem_req == 1'b0, {rq, " R3 hit no mem"}, 32'(mem_req), 32'd0);
         model_use(tg, st);
      end else begin
         chk(cpu_ready == 1'b0, {rq, " R4 no early ready"}, 32'(cpu_ready), 32'd0);
         for (int c = 1; c <= LAT; c++) begin
            @(negedge clk);
            if (c == LAT) begin
               mem_ack = 1'b1;
               for (int i = 0; i < 4; i++) mem_rline[i*32 +: 32] = mem_word(la + i);
            end
            #1;
            chk(mem_req == 1'b1, {rq, " R10 req held"}, 32'(mem_req), 32'd1);
            chk(mem_we == we, {rq, " R7 direction"}, 32'(mem_we), 32'(we));
            chk(mem_addr == exp_ma, {rq, " R2 mem_addr"}, mem_addr, exp_ma);
            if (we) begin
               chk(mem_wdata == wd, {rq, " R7 wdata"}, mem_wdata, wd);
               chk(mem_be == be, {rq, " R7 be"}, 32'(mem_be), 32'(be));
            end
            chk(cpu_ready == (c == LAT), {rq, " R7 ready on ack"}, 32'(cpu_ready), 32'(c == LAT));
         end
         if (!we) begin
            exp_rd = mem_word(wa);
            chk(cpu_rdata == exp_rd, {rq, " R4 refill data"}, cpu_rdata, exp_rd);
            model_use(tg, st);
         end else begin
            merged = mem_word(wa);
            for (int b = 0; b < 4; b++) if (be[b]) merged[b*8 +: 8] = wd[b*8 +: 8];
            mem_aa[wa] = merged;
            if (h) model_use(tg, st);
         end
      end
      idle(rq);
   endtask

   task automatic expect_hit(input logic [31:0] a, input bit exp_h, input string rq);
      bit h;
      h = model_hit(a[31:11], int'(a[10:4]));
      chk(h == exp_h, {rq, " model residency"}, 32'(h), 32'(exp_h));
      access(1'b0, a, 32'd0, 4'd0, rq);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: act=timeout exp=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 128; i++) begin
         rcnt[i] = 0; mru_t[i] = 0; lru_t[i] = 0;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(cpu_ready == 1'b0, "R1 reset ready", 32'(cpu_ready), 32'd0);
      chk(mem_req == 1'b0, "R1 reset mem_req", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      // set 5: fill two ways, then exercise recency
      expect_hit(mk(1, 5, 0), 1'b0, "R1 first read misses");
      expect_hit(mk(2, 5, 1), 1'b0, "R5 second tag fills");
      expect_hit(mk(1, 5, 3), 1'b1, "R5 first tag still resident");
      expect_hit(mk(2, 5, 2), 1'b1, "R5 second tag still resident");
      expect_hit(mk(1, 5, 0), 1'b1, "R6 touch tag1");
      expect_hit(mk(3, 5, 0), 1'b0, "R6 evict older");
      expect_hit(mk(1, 5, 1), 1'b1, "R6 recent kept");
      expect_hit(mk(2, 5, 1), 1'b0, "R6 evicted refetch");

      // write hit makes tag1 recent and merges bytes
      access(1'b1, mk(1, 5, 2), 32'hDEADBEEF, 4'b0101, "R8 write hit");
      expect_hit(mk(4, 5, 0), 1'b0, "R6 write hit counts as use");
      expect_hit(mk(1, 5, 2), 1'b1, "R8 merged word read");

      // write miss does not allocate
      access(1'b1, mk(9, 20, 1), 32'h01234567, 4'b1111, "R9 write miss");
      expect_hit(mk(9, 20, 1), 1'b0, "R9 read after write miss");
      expect_hit(mk(9, 20, 1), 1'b1, "R4 line valid after refill");

      // mixed traffic on a few conflicting sets
      for (int n = 0; n < 400; n++) begin
         int unsigned r;
         r = $urandom;
         access(r[3:0] < 4'd5, mk(int'(r[5:4]) + 1, int'(r[7:6]) % 3, int'(r[9:8])),
                $urandom, r[13:10], "R6 R8 mixed");
      end

      finish_run();
   end
endmodule